// File: doc/BRIEF.md
# UART Auxiliary Control: Wake-Up, DMA Request Routing and Transmit-Interrupt Select

This block holds one 16-bit auxiliary configuration register for a UART and the small amount of logic that the register steers. Eight low bits are writable; the upper byte always reads as zero. The block watches the receive-data, clear-to-send and data-set-ready pins. When wake-up is armed, a falling edge on any of them sets a sticky wake-up status flag and raises a wake-up interrupt. Only writing the wake-up enable back to zero clears the flag. A separate enable lets any change on data-set-ready produce a one-cycle interrupt pulse.

The block also decides where the transmit and receive DMA requests of the FIFOs go. It places them on two request lines according to a DMA mode. That mode is taken from the register's own 2-bit field or from a legacy enable bit of the FIFO control register, and a select bit in the register picks between the two. Finally, it chooses what raises the transmit-holding interrupt: the usual FIFO threshold signal, or both the transmit FIFO and the transmit shift register being empty. Two trigger-granularity bits are only stored and exported to the FIFO logic.

Register layout (bit: meaning): 7 receive trigger granularity-of-one, 6 transmit trigger granularity-of-one, 5 data-set-ready change interrupt enable, 4 wake-up enable, 3 transmit-empty interrupt control, 2:1 DMA mode field, 0 DMA mode source select.

Top module: `uart_aux_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `wake_stat`, `wake_irq`, `dsr_irq` and both `dma_req_o` bits are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[7:0]`, and it is visible on `cfg_rdata` after the next rising clock edge; `cfg_rdata[15:8]` always reads 0.
- R3: `rx_gran1` equals register bit 7 and `tx_gran1` equals register bit 6.
- R4: With register bit 4 (wake-up enable) at 1, a high-to-low transition on `rx_pin`, `cts_pin` or `dsr_pin` sets `wake_stat` within 4 clock cycles, and `wake_irq` is high while both `wake_stat` and bit 4 are 1.
- R5: Falling edges that occur while bit 4 is 0, and rising edges at any time, leave `wake_stat` at 0.
- R6: Once set, `wake_stat` stays 1 when the pin returns high and through writes that keep bit 4 at 1. It returns to 0 within 2 cycles of a write that sets bit 4 to 0.
- R7: With bit 5 at 1, each transition of `dsr_pin` (either direction) gives exactly one cycle of `dsr_irq`. With bit 5 at 0, `dsr_irq` stays 0.
- R8: With bit 0 at 1, the DMA mode is register bits 2:1. With bit 0 at 0, the mode is 1 when `fcr_dma_en` is 1 and 0 otherwise.
- R9: DMA mode 0 drives `dma_req_o` = 0. Mode 1 drives `dma_req_o[0]` = `tx_dma_req` and `dma_req_o[1]` = `rx_dma_req`. Mode 2 drives `dma_req_o[0]` = `rx_dma_req`, and mode 3 drives `dma_req_o[0]` = `tx_dma_req`; in modes 2 and 3 `dma_req_o[1]` is 0.
- R10: With bit 3 at 1, `thr_irq` = `tx_fifo_empty` AND `tx_shift_empty`. With bit 3 at 0, `thr_irq` = `tx_fifo_thr_hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| rx_pin | input | 1 | Receive-data line, asynchronous |
| cts_pin | input | 1 | Clear-to-send line, asynchronous |
| dsr_pin | input | 1 | Data-set-ready line, asynchronous |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_empty | input | 1 | Transmit shift register idle and empty |
| tx_fifo_thr_hit | input | 1 | Normal transmit-holding interrupt condition from the FIFO |
| fcr_dma_en | input | 1 | Legacy DMA enable from the FIFO control register |
| tx_dma_req | input | 1 | Transmit-side DMA request |
| rx_dma_req | input | 1 | Receive-side DMA request |
| dma_req_o | output | 2 | Routed DMA request lines |
| thr_irq | output | 1 | Transmit-holding interrupt |
| wake_irq | output | 1 | Wake-up interrupt |
| wake_stat | output | 1 | Sticky wake-up status flag |
| dsr_irq | output | 1 | Data-set-ready change pulse |
| rx_gran1 | output | 1 | Receive trigger granularity-of-one enable |
| tx_gran1 | output | 1 | Transmit trigger granularity-of-one enable |

## Verification
The DMA router is swept over every combination of source select, 2-bit field, legacy enable and the two request inputs. This shows apart the two mode sources as well as each line assignment, including mode 2 against mode 3. The transmit-interrupt select is swept over all sixteen combinations of its control bit and three status inputs, which shows apart the empty-and-idle rule from the threshold rule. Wake-up is driven on each of the three pins in turn. Further patterns cover an unarmed falling edge, a rising edge, a pin returning high, an unrelated rewrite, and clearing through the enable; these show apart edge detection, stickiness and the one clearing path. Data-set-ready changes are counted per transition with the enable on and off, which separates a single-cycle pulse from a level.

// File: rtl/uart_aux_pkg.sv
package uart_aux_pkg;

    localparam int REG_W = 16;
    localparam int CFG_W = 8;

    typedef struct packed {
        logic       rx_gran1;
        logic       tx_gran1;
        logic       dsr_ie;
        logic       wake_en;
        logic       txempty_ctl;
        logic [1:0] dma_field;
        logic       dma_src;
    } aux_cfg_t;

    typedef enum logic [1:0] {
        DMA_OFF    = 2'd0,
        DMA_SPLIT  = 2'd1,
        DMA_RXONLY = 2'd2,
        DMA_TXONLY = 2'd3
    } dma_mode_e;

endpackage

// File: rtl/uart_aux_cfg_reg.sv
module uart_aux_cfg_reg
    import uart_aux_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output aux_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        aux_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:CFG_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = aux_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[CFG_W-1:0] = st_q.cfg;
    end

    assign cfg = st_q.cfg;

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0]))); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata)); // R2

endmodule

// File: rtl/uart_wake_detect.sv
module uart_wake_detect #(
    parameter int NPINS   = 3,
    parameter int STAGES  = 2,
    parameter int DSR_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins,
    input  logic             wake_en,
    input  logic             dsr_ie,
    output logic             wake_flag,
    output logic             wake_irq,
    output logic             dsr_irq
);

    typedef struct packed {
        logic [STAGES-1:0][NPINS-1:0] sync;
        logic [NPINS-1:0]             prev;
        logic                         flag;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] synced;
    logic [NPINS-1:0] fall;

    assign synced = st_q.sync[STAGES-1];

    for (genvar i = 0; i < NPINS; i++) begin : g_fall
        assign fall[i] = st_q.prev[i] & ~synced[i];
    end

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pins;
        for (int s = 1; s < STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.prev = synced;
        if (!wake_en) begin
            st_d.flag = 1'b0;
        end else if (|fall) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.prev <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_flag = st_q.flag;
    assign wake_irq  = st_q.flag & wake_en;
    assign dsr_irq   = dsr_ie & (st_q.prev[DSR_IDX] ^ synced[DSR_IDX]);

    AST_WAKE_SET_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(wake_en)); // R4

    AST_WAKE_CLEAR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |=> !wake_flag); // R6

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && wake_en) |=> wake_flag); // R6

    AST_DSR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dsr_irq |-> dsr_ie); // R7

    AST_DSR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dsr_irq && $stable(pins) |=> !dsr_irq); // R7

endmodule

// File: rtl/uart_dma_route.sv
module uart_dma_route
    import uart_aux_pkg::*;
#(
    parameter int NREQ = 2
) (
    input  logic            dma_src,
    input  logic [1:0]      dma_field,
    input  logic            fcr_dma_en,
    input  logic            tx_req,
    input  logic            rx_req,
    output dma_mode_e       mode,
    output logic [NREQ-1:0] req
);

    always_comb begin
        if (dma_src) begin
            mode = dma_mode_e'(dma_field);
        end else begin
            mode = fcr_dma_en ? DMA_SPLIT : DMA_OFF;
        end
    end

    always_comb begin
        req = '0;
        unique case (mode)
            DMA_SPLIT: begin
                req[0] = tx_req;
                req[1] = rx_req;
            end
            DMA_RXONLY: req[0] = rx_req;
            DMA_TXONLY: req[0] = tx_req;
            default:    req    = '0;
        endcase
    end

endmodule

// File: rtl/uart_thr_sel.sv
module uart_thr_sel (
    input  logic txempty_ctl,
    input  logic fifo_empty,
    input  logic shift_empty,
    input  logic thr_hit,
    output logic thr_irq
);

    logic both_empty;

    always_comb begin
        both_empty = fifo_empty & shift_empty;
        thr_irq    = txempty_ctl ? both_empty : thr_hit;
    end

endmodule

// File: rtl/uart_aux_ctrl.sv
module uart_aux_ctrl
    import uart_aux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             rx_pin,
    input  logic             cts_pin,
    input  logic             dsr_pin,
    input  logic             tx_fifo_empty,
    input  logic             tx_shift_empty,
    input  logic             tx_fifo_thr_hit,
    input  logic             fcr_dma_en,
    input  logic             tx_dma_req,
    input  logic             rx_dma_req,
    output logic [1:0]       dma_req_o,
    output logic             thr_irq,
    output logic             wake_irq,
    output logic             wake_stat,
    output logic             dsr_irq,
    output logic             rx_gran1,
    output logic             tx_gran1
);

    localparam int NPINS   = 3;
    localparam int DSR_IDX = NPINS - 1;

    aux_cfg_t         cfg;
    dma_mode_e        dma_mode;
    logic [NPINS-1:0] pin_vec;

    assign pin_vec = {dsr_pin, cts_pin, rx_pin};

    uart_aux_cfg_reg #(
        .DATA_W (REG_W)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    uart_wake_detect #(
        .NPINS   (NPINS),
        .STAGES  (SYNC_STAGES),
        .DSR_IDX (DSR_IDX)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (pin_vec),
        .wake_en   (cfg.wake_en),
        .dsr_ie    (cfg.dsr_ie),
        .wake_flag (wake_stat),
        .wake_irq  (wake_irq),
        .dsr_irq   (dsr_irq)
    );

    uart_dma_route #(
        .NREQ (2)
    ) u_dma (
        .dma_src    (cfg.dma_src),
        .dma_field  (cfg.dma_field),
        .fcr_dma_en (fcr_dma_en),
        .tx_req     (tx_dma_req),
        .rx_req     (rx_dma_req),
        .mode       (dma_mode),
        .req        (dma_req_o)
    );

    uart_thr_sel u_thr (
        .txempty_ctl (cfg.txempty_ctl),
        .fifo_empty  (tx_fifo_empty),
        .shift_empty (tx_shift_empty),
        .thr_hit     (tx_fifo_thr_hit),
        .thr_irq     (thr_irq)
    );

    assign rx_gran1 = cfg.rx_gran1;
    assign tx_gran1 = cfg.tx_gran1;

    AST_DMA_IDLE_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode == DMA_OFF) |-> (dma_req_o == 2'b00)); // R9

    AST_DMA_LINE1_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o[1] |-> (dma_mode == DMA_SPLIT) && rx_dma_req); // R9

    AST_DMA_LEGACY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[0] && !fcr_dma_en) |-> (dma_req_o == 2'b00)); // R8

    AST_THR_EMPTY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3] && thr_irq) |-> (tx_fifo_empty && tx_shift_empty)); // R10

    AST_GRAN_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gran1 == cfg_rdata[7]) && (tx_gran1 == cfg_rdata[6])); // R3

endmodule

// File: tb/uart_aux_ctrl_tb.sv
module uart_aux_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rx_pin = 1'b1, cts_pin = 1'b1, dsr_pin = 1'b1;
    logic        tx_fifo_empty = 1'b0, tx_shift_empty = 1'b0, tx_fifo_thr_hit = 1'b0;
    logic        fcr_dma_en = 1'b0, tx_dma_req = 1'b0, rx_dma_req = 1'b0;
    logic [1:0]  dma_req_o;
    logic        thr_irq, wake_irq, wake_stat, dsr_irq, rx_gran1, tx_gran1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_aux_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_wdata       (cfg_wdata),
        .cfg_rdata       (cfg_rdata),
        .rx_pin          (rx_pin),
        .cts_pin         (cts_pin),
        .dsr_pin         (dsr_pin),
        .tx_fifo_empty   (tx_fifo_empty),
        .tx_shift_empty  (tx_shift_empty),
        .tx_fifo_thr_hit (tx_fifo_thr_hit),
        .fcr_dma_en      (fcr_dma_en),
        .tx_dma_req      (tx_dma_req),
        .rx_dma_req      (rx_dma_req),
        .dma_req_o       (dma_req_o),
        .thr_irq         (thr_irq),
        .wake_irq        (wake_irq),
        .wake_stat       (wake_stat),
        .dsr_irq         (dsr_irq),
        .rx_gran1        (rx_gran1),
        .tx_gran1        (tx_gran1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int idx, input logic v);
        case (idx)
            0:       rx_pin  = v;
            1:       cts_pin = v;
            default: dsr_pin = v;
        endcase
    endtask

    task automatic count_dsr(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dsr_irq) cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [1:0] mode;
        logic [1:0] exp_req;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 wake_stat", wake_stat, 0);
        chk("R1 wake_irq", wake_irq, 0);
        chk("R1 dsr_irq", dsr_irq, 0);
        chk("R1 dma_req", dma_req_o, 0);

        // R2 and R3: readback and reserved bits, granularity outputs
        for (int v = 0; v < 256; v += 17) begin
            wr(16'hA500 | 16'(v));
            chk("R2 readback", cfg_rdata, 32'(v));
            chk("R3 rx_gran1", rx_gran1, 32'((v >> 7) & 1));
            chk("R3 tx_gran1", tx_gran1, 32'((v >> 6) & 1));
        end
        wr(16'hFFCF);
        chk("R2 reserved zero", cfg_rdata, 32'h00CF);
        wr(16'h0000);

        // R8, R9: exhaustive DMA routing sweep
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 4; f++) begin
                wr(16'((f << 1) | s));
                for (int l = 0; l < 2; l++)
                    for (int t = 0; t < 2; t++)
                        for (int r = 0; r < 2; r++) begin
                            @(negedge clk);
                            fcr_dma_en = l[0];
                            tx_dma_req = t[0];
                            rx_dma_req = r[0];
                            #1;
                            mode = (s == 1) ? 2'(f) : 2'(l);
                            case (mode)
                                2'd1:    exp_req = {r[0], t[0]};
                                2'd2:    exp_req = {1'b0, r[0]};
                                2'd3:    exp_req = {1'b0, t[0]};
                                default: exp_req = 2'b00;
                            endcase
                            chk(s == 1 ? "R9 R8 field mode" : "R8 R9 legacy mode",
                                dma_req_o, exp_req);
                        end
            end
        fcr_dma_en = 0; tx_dma_req = 0; rx_dma_req = 0;

        // R10: transmit-holding interrupt select sweep
        for (int c = 0; c < 2; c++) begin
            wr(16'(c << 3));
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                tx_fifo_empty   = p[0];
                tx_shift_empty  = p[1];
                tx_fifo_thr_hit = p[2];
                #1;
                chk("R10 thr_irq", thr_irq,
                    (c == 1) ? 32'(p[0] & p[1]) : 32'(p[2]));
            end
        end

        // R4, R6: wake-up on each pin, stickiness and clearing
        for (int i = 0; i < 3; i++) begin
            wr(16'h0010);
            wait_n(4);
            chk("R4 idle no wake", wake_stat, 0);
            set_pin(i, 1'b0);
            wait_n(4);
            chk("R4 wake_stat set", wake_stat, 1);
            chk("R4 wake_irq set", wake_irq, 1);
            set_pin(i, 1'b1);
            wait_n(4);
            chk("R6 sticky after pin high", wake_stat, 1);
            wr(16'h0090);
            wait_n(2);
            chk("R6 sticky through rewrite", wake_stat, 1);
            chk("R6 irq through rewrite", wake_irq, 1);
            wr(16'h0000);
            wait_n(1);
            chk("R6 cleared stat", wake_stat, 0);
            chk("R6 cleared irq", wake_irq, 0);
        end

        // R5: falling edge while disarmed, then rising edge while armed
        wr(16'h0000);
        cts_pin = 1'b0;
        wait_n(5);
        chk("R5 disarmed fall", wake_stat, 0);
        wr(16'h0010);
        wait_n(5);
        chk("R5 arm after low", wake_stat, 0);
        cts_pin = 1'b1;
        wait_n(5);
        chk("R5 rising edge", wake_stat, 0);
        chk("R5 rising edge irq", wake_irq, 0);
        wr(16'h0000);

        // R7: data-set-ready change pulses
        wr(16'h0020);
        wait_n(2);
        dsr_pin = 1'b0;
        count_dsr(6, cnt);
        chk("R7 pulse on fall", cnt, 1);
        dsr_pin = 1'b1;
        count_dsr(6, cnt);
        chk("R7 pulse on rise", cnt, 1);
        wr(16'h0000);
        dsr_pin = 1'b0;
        count_dsr(6, cnt);
        chk("R7 disabled fall", cnt, 0);
        dsr_pin = 1'b1;
        count_dsr(6, cnt);
        chk("R7 disabled rise", cnt, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule